// File: doc/BRIEF.md
# ROM-to-RAM block copy engine with bus takeover

This block moves a run of bytes out of the cartridge ROM into the host computer's main memory while the host CPU is held off the bus. Software loads a source ROM address, a destination RAM address and a byte count into six byte-wide I/O registers. The write to the upper count byte starts the copy. The engine then pulls the bus-request line low. It waits, for as long as needed, until the CPU answers with bus acknowledge.

While it owns the bus, the engine handles one byte per fixed-length slot. In each slot it reads the ROM at the source address and places the destination address and the data on the host bus. It then pulses memory-request and write low together and steps both addresses. With the default slot length of 16 clocks at 16 MHz, this gives one byte per microsecond. After the last byte, the engine first floats its bus drivers and only then lets go of bus request. A completion flag stays set until the next copy starts. A count of zero means the largest possible copy, which for the default 16-bit count covers a full 16 KiB screen several times over.

Top module: `rom_copy_dma`

## Requirements
- R1: Register select codes on `io_sel` are: 0 source low byte, 1 source high byte, 2 destination low byte, 3 destination high byte, 4 count low byte, 5 count high byte. A write with code 5 while idle starts a copy. Count bits at and above CNT_W are ignored. Programmed values persist across copies, so a new start without reprogramming reuses the same source and destination.
- R2: A count value N with 1 <= N < 2^CNT_W copies exactly N bytes. A count of 0 copies 2^CNT_W bytes.
- R3: After a start, `busreq_n` goes low and stays low until after the last write. `bus_oe` stays low until `busack_n` has been seen low, and an acknowledge delay of any length is tolerated.
- R4: Successive write strobes begin exactly SLOT_CLKS clocks apart.
- R5: For each byte, `mreq_n` and `wr_n` go low together for exactly STROBE_CLKS clocks, and only while `bus_oe` is high.
- R6: Byte i of a copy is written to address (dst + i) mod 65536 with the ROM content at (src + i) mod 65536.
- R7: On completion, `bus_oe` is low for at least one clock before `busreq_n` returns high.
- R8: `done` reads 0 from the start of a copy until the bus is released, then reads 1 until the next start. `busy` is high exactly while bus request is held.
- R9: Register writes made while a copy is in progress (including a code-5 write) are ignored.
- R10: After reset, `busreq_n`, `mreq_n` and `wr_n` are high, and `bus_oe`, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Register write strobe, one clock |
| io_sel | input | 3 | Register select code |
| io_wdata | input | 8 | Register write data |
| busreq_n | output | 1 | Bus request to the CPU, active low |
| busack_n | input | 1 | Bus acknowledge from the CPU, active low |
| bus_oe | output | 1 | Enable for the address, data and strobe drivers |
| mreq_n | output | 1 | Memory request strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| host_addr | output | 16 | Destination address on the host bus |
| host_wdata | output | 8 | Data byte on the host bus |
| rom_addr | output | 16 | Cartridge ROM read address |
| rom_data | input | 8 | Cartridge ROM read data, valid the clock after the address |
| busy | output | 1 | Copy in progress |
| done | output | 1 | Completion flag |

## Verification
The bench builds the engine with a 9-bit count, a 6-clock slot and a 2-clock strobe. With the 9-bit count, the zero-means-maximum case becomes a 512-byte copy that runs in a few thousand cycles, and the count bits above the width can be tested as ignored. The short slot lets the bench sweep every count from 1 to 12 against acknowledge delays of 0 to 3 clocks. In each case it checks every write's address, data, strobe width and slot spacing. Separate runs cover address wrap past 0xFFFF, a long acknowledge stall during which register writes are attempted, and a restart that reuses the stored addresses.

// File: rtl/romdma_pkg.sv
package romdma_pkg;
  localparam int ADDR_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_MOVE,
    ST_LET_GO
  } dma_state_e;

  typedef enum logic [2:0] {
    SEL_SRC_LO = 3'd0,
    SEL_SRC_HI = 3'd1,
    SEL_DST_LO = 3'd2,
    SEL_DST_HI = 3'd3,
    SEL_CNT_LO = 3'd4,
    SEL_CNT_HI = 3'd5
  } reg_sel_e;

  // Address step with natural wrap at the top of the space
  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import romdma_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [2:0]        io_sel,
  input  logic [7:0]        io_wdata,
  input  logic              idle,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic [CNT_W-1:0]  cnt_raw,
  output logic              start_q
);
  logic [15:0] cnt_full;
  logic        accept;

  // Writes count only while the engine sits idle and no start is pending
  assign accept  = io_wr && idle && !start_q;
  assign cnt_raw = cnt_full[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q    <= '0;
      dst_q    <= '0;
      cnt_full <= '0;
      start_q  <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (accept) begin
        case (io_sel)
          SEL_SRC_LO: src_q[7:0]     <= io_wdata;
          SEL_SRC_HI: src_q[15:8]    <= io_wdata;
          SEL_DST_LO: dst_q[7:0]     <= io_wdata;
          SEL_DST_HI: dst_q[15:8]    <= io_wdata;
          SEL_CNT_LO: cnt_full[7:0]  <= io_wdata;
          SEL_CNT_HI: begin
            cnt_full[15:8] <= io_wdata;
            start_q        <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> $past(idle)) else $error("start outside idle"); // R9
endmodule

// File: rtl/dma_slot_timer.sv
module dma_slot_timer #(
  parameter int SLOT_CLKS   = 16,
  parameter int STROBE_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic grab,
  output logic strobe,
  output logic slot_end
);
  localparam int PH_W = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;
  localparam logic [PH_W-1:0] PH_GRAB  = PH_W'(1);
  localparam logic [PH_W-1:0] PH_STB0  = PH_W'(2);
  localparam logic [PH_W-1:0] PH_STBN  = PH_W'(2 + STROBE_CLKS);
  localparam logic [PH_W-1:0] PH_LAST  = PH_W'(SLOT_CLKS - 1);

  logic [PH_W-1:0] ph;

  // Phase 0 reads ROM, phase 1 latches data, then the strobe window, last phase steps
  assign grab     = run && (ph == PH_GRAB);
  assign strobe   = run && (ph >= PH_STB0) && (ph < PH_STBN);
  assign slot_end = run && (ph == PH_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run)   ph <= '0;
    else if (ph == PH_LAST) ph <= '0;
    else                  ph <= ph + PH_W'(1);
  end

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ph <= PH_LAST) else $error("phase out of range"); // R4
  AST_STROBE_BEFORE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |-> !strobe) else $error("strobe overlaps address step"); // R5
endmodule

// File: rtl/rom_copy_dma.sv
module rom_copy_dma
  import romdma_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SLOT_CLKS   = 16,
  parameter int STROBE_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [2:0]        io_sel,
  input  logic [7:0]        io_wdata,
  output logic              busreq_n,
  input  logic              busack_n,
  output logic              bus_oe,
  output logic              mreq_n,
  output logic              wr_n,
  output logic [ADDR_W-1:0] host_addr,
  output logic [7:0]        host_wdata,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [7:0]        rom_data,
  output logic              busy,
  output logic              done
);
  localparam int REM_W = CNT_W + 1;

  // Byte total for a programmed count; zero selects the full range
  function automatic logic [REM_W-1:0] bytes_for(input logic [CNT_W-1:0] raw);
    return (raw == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, raw};
  endfunction

  dma_state_e        state;
  logic [ADDR_W-1:0] src_q, dst_q, src_c, dst_c;
  logic [CNT_W-1:0]  cnt_raw;
  logic [REM_W-1:0]  rem;
  logic [7:0]        data_q;
  logic              start_q, idle, moving, grab, strobe, slot_end;
  logic              last_byte;

  assign idle      = (state == ST_IDLE);
  assign moving    = (state == ST_MOVE);
  assign last_byte = (rem == REM_W'(1));

  dma_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_sel(io_sel),
    .io_wdata(io_wdata), .idle(idle), .src_q(src_q), .dst_q(dst_q),
    .cnt_raw(cnt_raw), .start_q(start_q)
  );

  dma_slot_timer #(.SLOT_CLKS(SLOT_CLKS), .STROBE_CLKS(STROBE_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(moving),
    .grab(grab), .strobe(strobe), .slot_end(slot_end)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      src_c  <= '0;
      dst_c  <= '0;
      rem    <= '0;
      data_q <= '0;
      done   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start_q) begin
          state <= ST_REQ;
          src_c <= src_q;
          dst_c <= dst_q;
          rem   <= bytes_for(cnt_raw);
          done  <= 1'b0;
        end
        ST_REQ: if (!busack_n) state <= ST_MOVE;
        ST_MOVE: begin
          if (grab) data_q <= rom_data;
          if (slot_end) begin
            src_c <= addr_step(src_c);
            dst_c <= addr_step(dst_c);
            rem   <= rem - REM_W'(1);
            if (last_byte) state <= ST_LET_GO;
          end
        end
        default: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
      endcase
    end
  end

  assign busreq_n   = idle;
  assign busy       = !idle;
  assign bus_oe     = moving;
  assign mreq_n     = !strobe;
  assign wr_n       = !strobe;
  assign host_addr  = dst_c;
  assign host_wdata = data_q;
  assign rom_addr   = src_c;

  AST_DRIVE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !busack_n) else $error("drive without ack"); // R3
  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !busreq_n) else $error("drive without request"); // R3
  AST_FLOAT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busreq_n) |-> !$past(bus_oe)) else $error("release while driving"); // R7
  AST_STROBE_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (bus_oe && !mreq_n)) else $error("strobe outside ownership"); // R5
  AST_DONE_LOW_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    !busreq_n |-> !done) else $error("done during copy"); // R8
  AST_REM_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    moving |-> (rem != '0)) else $error("count underflow"); // R2
endmodule

// File: tb/rom_copy_dma_tb.sv
module rom_copy_dma_tb;
  localparam int CNT_W  = 9;
  localparam int SLOT   = 6;
  localparam int STROBE = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_wr = 1'b0;
  logic [2:0] io_sel = '0;
  logic [7:0] io_wdata = '0;
  logic busack_n = 1'b1;
  logic busreq_n, bus_oe, mreq_n, wr_n, busy, done;
  logic [15:0] host_addr, rom_addr;
  logic [7:0] host_wdata, rom_data;

  int n_chk = 0, n_err = 0, cyc = 0;
  int ack_dly = 0, ack_ctr = 0;
  logic [15:0] cur_src, cur_dst, last_src, last_dst;
  int idx, last_fall, low_cnt;
  bit prev_wr = 1'b1, prev_req = 1'b1, prev_oe = 1'b0;
  bit bad_ack, bad_req, bad_rel;

  always #4 clk = ~clk;

  function automatic logic [7:0] rom_fn(input logic [15:0] a);
    return (a[7:0] + 8'(a[15:8] * 3)) ^ 8'h5A;
  endfunction
  assign rom_data = rom_fn(rom_addr);

  rom_copy_dma #(.CNT_W(CNT_W), .SLOT_CLKS(SLOT), .STROBE_CLKS(STROBE)) u_dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_sel(io_sel), .io_wdata(io_wdata),
    .busreq_n(busreq_n), .busack_n(busack_n), .bus_oe(bus_oe), .mreq_n(mreq_n),
    .wr_n(wr_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .rom_addr(rom_addr), .rom_data(rom_data), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // CPU model: acknowledges after ack_dly clocks of request
  always @(negedge clk) begin
    if (busreq_n) begin
      busack_n = 1'b1;
      ack_ctr = 0;
    end else if (ack_ctr >= ack_dly) busack_n = 1'b0;
    else ack_ctr++;
  end

  // Host bus monitor
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (bus_oe && busack_n) bad_ack = 1'b1;
      if (bus_oe && busreq_n) bad_req = 1'b1;
      if (busreq_n && !prev_req && prev_oe) bad_rel = 1'b1;
      if (!wr_n && prev_wr) begin
        check(host_addr == 16'(cur_dst + idx), "R6 address", host_addr, 16'(cur_dst + idx));
        check(host_wdata == rom_fn(16'(cur_src + idx)), "R6 data", host_wdata, rom_fn(16'(cur_src + idx)));
        check(!mreq_n, "R5 mreq with wr", mreq_n, 0);
        if (idx > 0) check(cyc - last_fall == SLOT, "R4 slot spacing", cyc - last_fall, SLOT);
        last_fall = cyc;
        low_cnt = 1;
        idx++;
      end else if (!wr_n) low_cnt++;
      if (wr_n && !prev_wr) check(low_cnt == STROBE, "R5 strobe width", low_cnt, STROBE);
    end
    prev_wr = wr_n;
    prev_req = busreq_n;
    prev_oe = bus_oe;
  end

  always @(negedge clk) begin
    if (cyc > 150000) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic io_write(input logic [2:0] sel, input logic [7:0] val);
    io_sel = sel;
    io_wdata = val;
    io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_copy(input logic [15:0] s, input logic [15:0] d, input logic [15:0] c,
                          input int dly, input bit prog, input bit inject);
    int exp_n;
    exp_n = (c[CNT_W-1:0] == '0) ? (1 << CNT_W) : int'(c[CNT_W-1:0]);
    if (prog) begin
      last_src = s;
      last_dst = d;
    end
    cur_src = last_src;
    cur_dst = last_dst;
    idx = 0;
    bad_ack = 0; bad_req = 0; bad_rel = 0;
    ack_dly = dly;
    if (prog) begin
      io_write(3'd0, s[7:0]);  io_write(3'd1, s[15:8]);
      io_write(3'd2, d[7:0]);  io_write(3'd3, d[15:8]);
    end
    io_write(3'd4, c[7:0]);
    io_write(3'd5, c[15:8]);
    while (!busy) @(negedge clk);
    check(done == 1'b0, "R8 done cleared at start", done, 0);
    check(busreq_n == 1'b0, "R3 request asserted", busreq_n, 0);
    if (inject) begin
      io_write(3'd0, 8'hAA);
      io_write(3'd2, 8'h55);
      io_write(3'd5, 8'h00);
      check(bus_oe == 1'b0, "R3 no drive during stall", bus_oe, 0);
    end
    while (busy) @(negedge clk);
    check(idx == exp_n, "R2 byte count", idx, exp_n);
    check(done == 1'b1, "R8 done after release", done, 1);
    check(busreq_n == 1'b1, "R8 busy matches request", busreq_n, 1);
    check(!bad_ack, "R3 drive only after ack", bad_ack, 0);
    check(!bad_req, "R3 request held while driving", bad_req, 0);
    check(!bad_rel, "R7 float before release", bad_rel, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busreq_n == 1'b1 && mreq_n == 1'b1 && wr_n == 1'b1, "R10 strobes idle",
          {busreq_n, mreq_n, wr_n}, 3'b111);
    check(bus_oe == 1'b0 && busy == 1'b0 && done == 1'b0, "R10 outputs low",
          {bus_oe, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_copy(16'h1234, 16'hC000, 16'h0001, 0, 1, 0);   // R2 single byte
    for (int n = 1; n <= 12; n++)                       // R4 R6 sweep
      run_copy(16'h0100 + 16'(n * 7), 16'h4000 + 16'(n * 33), 16'(n), n % 4, 1, 0);
    run_copy(16'hFFFE, 16'hFFFD, 16'h0006, 2, 1, 0);   // R6 address wrap
    run_copy(16'h2000, 16'h8000, 16'h0A05, 1, 1, 0);   // R1 upper count bits ignored
    run_copy(16'h3000, 16'h9000, 16'h012C, 0, 1, 0);   // R2 300 bytes
    run_copy(16'h0040, 16'hC100, 16'h0004, 20, 1, 1);  // R9 writes during stall ignored
    run_copy(16'h0000, 16'h0000, 16'h0003, 1, 0, 0);   // R1 restart reuses stored addresses
    run_copy(16'h5555, 16'h0010, 16'h0000, 3, 1, 0);   // R2 zero means full range
    repeat (5) @(negedge clk);
    check(done == 1'b1, "R8 done holds while idle", done, 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule